// File: doc/BRIEF.md
# Consensus Controlled-Clock Advance Controller

This block derives a controlled clock for an emulation-style design from a single free-running uncontrolled clock. Any number of peer participants can take part, for example hardware transactors or a software-driven register that steps the clock. Each participant drives one ready line. The controlled clock moves forward only when all participants are ready in the same uncontrolled cycle. No participant has priority over the others, and none owns the clock.

The controlled clock is not produced as a gated clock. It appears as a one-bit enable, synchronous to the uncontrolled clock. Every uncontrolled cycle in which the enable is high counts as one controlled edge. The same enable goes to every participant as the second half of its dual-ready pair: a participant's edge transfer completes on a cycle where its own ready line and the shared enable are both true.

The decision takes one uncontrolled cycle: the enable is registered from the combinational all-ready term. A counter of granted edges can be included through a parameter. A test environment uses it to compare the number of edges it expected with the number that occurred.

Top module: `clk_advance_ctrl`

## Requirements
- R1: While reset (active-low, asynchronous) is asserted, the enable output is low and the edge count is zero, even when every ready bit is high.
- R2: When all NUM_PEERS ready bits are high at a rising uncontrolled edge, the enable is high for the following uncontrolled cycle.
- R3: When any single ready bit is low at a rising edge, the enable is low for the following cycle, whichever bit it is.
- R4: If all ready bits stay high for K consecutive sampled edges, the enable is high for exactly K consecutive cycles. A single all-ready cycle gives a single one-cycle pulse.
- R5: Partial readiness is not remembered. Ready bits that are high at different times, but never all high together, grant no edge and leave the count unchanged. A later all-ready cycle then grants exactly one edge.
- R6: The edge count rises by exactly one on each clock edge that sets the enable high and holds its value otherwise. It therefore always equals the number of enable-high cycles since reset, including the current one.
- R7: One ready bit alone, such as a software-controlled participant, can hold the controlled clock stopped indefinitely while all other bits are high. It then releases edges one at a time by pulsing its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| uclk_i | input | 1 | Free-running uncontrolled clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ready_i | input | NUM_PEERS | Ready-for-next-controlled-edge, one bit per participant |
| cclk_en_o | output | 1 | Controlled-clock enable, high for each controlled edge |
| edge_count_o | output | CNT_W | Number of controlled edges granted since reset |

## Verification
The bench drives all ready bits high during reset. A design whose reset does not dominate would grant an edge while reset is still asserted. It clears each ready bit in turn with all the others set. A design that reduced only part of the vector, or dropped one participant, would still grant an edge there. It also raises the ready bits at staggered times without any cycle where all are high. A design that latched partial requests would grant a phantom edge, and its count would move ahead of the enable pulses. Long all-ready runs and isolated one-cycle pulses are mixed with random vectors biased toward all-ones. This exposes a latency off by one, stretched or merged pulses, and a counter that misses back-to-back grants.

// File: rtl/cca_pkg.sv
package cca_pkg;

    localparam int unsigned DEFAULT_PEERS = 4;
    localparam int unsigned DEFAULT_CNT_W = 32;

    // Registered state of the grant stage.
    typedef struct packed {
        logic grant;
    } grant_state_t;

endpackage

// File: rtl/cca_consensus.sv
module cca_consensus #(
    parameter int unsigned NUM_PEERS = 4
) (
    input  logic [NUM_PEERS-1:0] ready_i,
    output logic                 all_ready_o
);

    // Chain of partial products: link[i] is high when bits below i are all ready.
    logic [NUM_PEERS:0] link;

    assign link[0] = 1'b1;

    for (genvar i = 0; i < NUM_PEERS; i++) begin : g_link
        assign link[i+1] = link[i] & ready_i[i];
    end

    assign all_ready_o = link[NUM_PEERS];

endmodule

// File: rtl/cca_edge_counter.sv
module cca_edge_counter #(
    parameter int unsigned CNT_W      = 32,
    parameter bit          HAS_COUNTER = 1'b1
) (
    input  logic             uclk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o
);

    if (HAS_COUNTER) begin : g_count
        logic [CNT_W-1:0] count_d, count_q;

        always_comb begin
            count_d = count_q;
            if (step_i) begin
                count_d = count_q + CNT_W'(1);
            end
        end

        always_ff @(posedge uclk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                count_q <= '0;
            end else begin
                count_q <= count_d;
            end
        end

        assign count_o = count_q;
    end else begin : g_no_count
        logic unused_step;
        assign unused_step = step_i;
        assign count_o     = '0;
    end

endmodule

// File: rtl/clk_advance_ctrl.sv
module clk_advance_ctrl
    import cca_pkg::*;
#(
    parameter int unsigned NUM_PEERS   = DEFAULT_PEERS,
    parameter int unsigned CNT_W       = DEFAULT_CNT_W,
    parameter bit          HAS_COUNTER = 1'b1
) (
    input  logic                 uclk_i,
    input  logic                 rst_ni,
    input  logic [NUM_PEERS-1:0] ready_i,
    output logic                 cclk_en_o,
    output logic [CNT_W-1:0]     edge_count_o
);

    logic         all_ready;
    grant_state_t state_d, state_q;

    cca_consensus #(
        .NUM_PEERS (NUM_PEERS)
    ) u_consensus (
        .ready_i     (ready_i),
        .all_ready_o (all_ready)
    );

    // Next-state: grant the coming controlled edge only on full consensus.
    always_comb begin
        state_d       = state_q;
        state_d.grant = all_ready;
    end

    always_ff @(posedge uclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    cca_edge_counter #(
        .CNT_W       (CNT_W),
        .HAS_COUNTER (HAS_COUNTER)
    ) u_counter (
        .uclk_i  (uclk_i),
        .rst_ni  (rst_ni),
        .step_i  (state_d.grant),
        .count_o (edge_count_o)
    );

    assign cclk_en_o = state_q.grant;

endmodule

// File: rtl/cca_checker.sv
module cca_checker #(
    parameter int unsigned NUM_PEERS   = 4,
    parameter int unsigned CNT_W       = 32,
    parameter bit          HAS_COUNTER = 1'b1
) (
    input logic                 uclk_i,
    input logic                 rst_ni,
    input logic [NUM_PEERS-1:0] ready_i,
    input logic                 cclk_en_o,
    input logic [CNT_W-1:0]     edge_count_o
);

    AST_RESET_QUIET: assert property (@(posedge uclk_i)
        !rst_ni |-> (!cclk_en_o && edge_count_o == '0)); // R1

    AST_GRANT_ON_CONSENSUS: assert property (@(posedge uclk_i) disable iff (!rst_ni)
        (&ready_i) |=> cclk_en_o); // R2

    AST_NO_GRANT_WITHOUT_ALL: assert property (@(posedge uclk_i) disable iff (!rst_ni)
        !(&ready_i) |=> !cclk_en_o); // R3

    AST_COUNT_STEPS: assert property (@(posedge uclk_i) disable iff (!rst_ni)
        (HAS_COUNTER && $rose(cclk_en_o)) |-> (edge_count_o == $past(edge_count_o) + CNT_W'(1))); // R6

    AST_COUNT_HOLDS: assert property (@(posedge uclk_i) disable iff (!rst_ni)
        !cclk_en_o |-> $stable(edge_count_o)); // R6

endmodule

bind clk_advance_ctrl cca_checker #(
    .NUM_PEERS   (NUM_PEERS),
    .CNT_W       (CNT_W),
    .HAS_COUNTER (HAS_COUNTER)
) u_cca_checker (
    .uclk_i       (uclk_i),
    .rst_ni       (rst_ni),
    .ready_i      (ready_i),
    .cclk_en_o    (cclk_en_o),
    .edge_count_o (edge_count_o)
);

// File: tb/test_clk_advance_ctrl.sv
`timescale 1ns/1ps
module test_clk_advance_ctrl;

    localparam int unsigned N = 4;
    localparam int unsigned W = 32;

    logic         uclk = 1'b0;
    logic         rst_n;
    logic [N-1:0] ready;
    logic         en;
    logic [W-1:0] cnt;

    int unsigned errors = 0;
    int unsigned checks = 0;
    bit          done   = 1'b0;

    logic         exp_en;
    logic [W-1:0] exp_cnt;
    string        pend_tag;

    always #2.5 uclk = ~uclk;

    clk_advance_ctrl #(.NUM_PEERS(N), .CNT_W(W), .HAS_COUNTER(1'b1)) i_clk_advance_ctrl (
        .uclk_i       (uclk),
        .rst_ni       (rst_n),
        .ready_i      (ready),
        .cclk_en_o    (en),
        .edge_count_o (cnt)
    );

    function automatic logic consensus(input logic [N-1:0] r);
        return &r;
    endfunction

    task automatic check_en(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s enable: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_cnt(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s count: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // At each falling edge: check the result of the previous vector, then apply the next.
    task automatic step(input logic [N-1:0] r, input string tag);
        @(negedge uclk);
        check_en(en, exp_en, pend_tag);
        check_cnt(cnt, exp_cnt, pend_tag);
        ready    = r;
        pend_tag = tag;
        exp_en   = consensus(r);
        if (consensus(r)) exp_cnt = exp_cnt + W'(1);
    endtask

    initial begin
        void'($urandom(32'd20011115));
        rst_n   = 1'b0;
        ready   = '1;
        exp_en  = 1'b0;
        exp_cnt = '0;

        // R1: reset dominates an all-ready vector.
        repeat (3) begin
            @(negedge uclk);
            check_en(en, 1'b0, "R1");
            check_cnt(cnt, '0, "R1");
        end
        ready    = '0;
        rst_n    = 1'b1;
        pend_tag = "R1";

        step('0, "R3");
        // R2: single all-ready cycle gives one pulse one cycle later (R4).
        step('1, "R2");
        step('0, "R4");
        step('0, "R4");
        // R4: run of five all-ready cycles gives five enables.
        repeat (5) step('1, "R4");
        step('0, "R4");

        // R3: each participant alone blocks the edge.
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] r;
            r    = '1;
            r[i] = 1'b0;
            step(r, "R3");
        end
        step('0, "R3");

        // R5: staggered readiness never all high at once.
        for (int i = 0; i < N; i++) begin
            step(N'(1) << i, "R5");
        end
        step(N'(5), "R5");
        step(N'(10), "R5");
        step('1, "R5");
        step('0, "R5");

        // R7: bit 0 as software participant holds then single-steps the clock.
        repeat (6) step({{(N-1){1'b1}}, 1'b0}, "R7");
        for (int k = 0; k < 3; k++) begin
            step('1, "R7");
            step({{(N-1){1'b1}}, 1'b0}, "R7");
            step({{(N-1){1'b1}}, 1'b0}, "R7");
        end

        // R6: random vectors biased toward consensus; count tracks every grant.
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] r;
            r = N'($urandom);
            if ($urandom_range(0, 1) == 0) r = '1;
            step(r, "R6");
        end
        step('0, "R6");
        step('0, "R6");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge uclk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule